// File: doc/BRIEF.md
# Set/Clear GPIO Controller

This block is a register-mapped general-purpose I/O controller. A host reaches it over a plain 32-bit register bus with an address, a write strobe, write data, a read strobe and read data. The block holds the output levels and output enables for three ordinary bidirectional ports of 8, 24 and 13 pins.

A fourth group gathers six more bidirectional pins, 23 input-only pins and 24 output-only pins. The bits of this group are packed irregularly into shared registers. The direction bits of its six bidirectional pins sit in the upper part of the direction register of the 13-pin port.

Output and direction registers are changed only through write-one-to-set and write-one-to-clear addresses, so software never has to do a read-modify-write. Every input pad passes through a two-stage synchronizer before it becomes visible in an input-state register.

Top module: `setclr_gpio`

## Requirements
- R1: While reset is asserted and after it is released, every pad output, every output enable and every output-only pin is low, and every readable register returns zero (inputs held low).
- R2: The address map is as follows.
  - Port A (8 pins) uses 0x40 input state, 0x44 output set, 0x48 output clear, 0x4C output state, 0x50 direction set, 0x54 direction clear and 0x58 direction state.
  - Port B (24 pins) uses the same layout at 0x60 to 0x78.
  - Port C (13 pins) uses 0x10 direction set, 0x14 direction clear, 0x18 direction state, 0x1C input state, 0x20 output set and 0x24 output clear.
  - The extra group uses 0x00 input state, 0x04 output set, 0x08 output clear and 0x0C output state.
  - For ports A, B and C, pin n is bit n.
- R3: In an output set or clear write, each 1 bit drives the matching pin's output high (set) or low (clear), and each 0 bit leaves its pin unchanged. The new level is on the pad after the clock edge that takes the write.
- R4: A 1 in a direction-set bit makes that pin an output (enable high). A 1 in a direction-clear bit makes it an input (enable low). The direction-state register reads back the enables.
- R5: The direction registers at 0x10, 0x14 and 0x18 are shared. Bits 0 to 12 belong to port C and bits 25 to 30 belong to the extra group's bidirectional pins 0 to 5. One write can change pins of both. All other bits are ignored on write and read as zero.
- R6: Bits 0 to 23 of the extra group's output set, clear and state registers drive the 24 output-only pins, which have no enable. Bits 25 to 30 of the same registers are the levels of its bidirectional pins 0 to 5. Bits 24 and 31 are ignored and read as zero.
- R7: The extra group's input state at 0x00 is laid out as follows, and bits 29 to 31 read zero.
  - Input-only pins 0 to 9 appear on bits 0 to 9, pins 10 to 18 on bits 15 to 23, and pins 19 to 22 on bits 25 to 28.
  - Bidirectional pins 0 to 4 appear on bits 10 to 14, and bidirectional pin 5 appears on bit 24.
- R8: A pad level change appears in its input-state register after exactly two rising clock edges. A read after only one edge still returns the old level.
- R9: Writes to input-state, output-state, direction-state and unmapped addresses change nothing. Reads from unmapped addresses return zero.
- R10: Read data is zero whenever the read strobe is low. Set and clear addresses read as zero. A cycle that carries both a read and a write to the same address still performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |
| pa_in | input | 8 | Port A pad inputs |
| pa_out | output | 8 | Port A pad output levels |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 24 | Port B pad inputs |
| pb_out | output | 24 | Port B pad output levels |
| pb_oe | output | 24 | Port B output enables |
| pc_in | input | 13 | Port C pad inputs |
| pc_out | output | 13 | Port C pad output levels |
| pc_oe | output | 13 | Port C output enables |
| px_io_in | input | 6 | Extra group bidirectional pad inputs |
| px_io_out | output | 6 | Extra group bidirectional output levels |
| px_io_oe | output | 6 | Extra group bidirectional output enables |
| px_ipin | input | 23 | Extra group input-only pins |
| px_opin | output | 24 | Extra group output-only pins |

## Verification
Two things can fall in the same cycle. First, a pad edge and a read of its input-state register: the bench changes a pad right before a read and checks that the read one edge later still shows the old level, while the read two edges later shows the new one. Second, a read and a write on the same bus cycle: the bench raises both strobes to a set address and checks that the read returns zero while the pad still takes the new level. Around these directed cases, seeded random writes to all 32 word addresses are compared against a bench model of the registers, pad by pad and readback by readback.

// File: rtl/setclr_gpio.sv
module setclr_gpio #(
  parameter int ADDR_W = 8,
  parameter int PA_W   = 8,
  parameter int PB_W   = 24,
  parameter int PC_W   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [PA_W-1:0]   pa_in,
  output logic [PA_W-1:0]   pa_out,
  output logic [PA_W-1:0]   pa_oe,
  input  logic [PB_W-1:0]   pb_in,
  output logic [PB_W-1:0]   pb_out,
  output logic [PB_W-1:0]   pb_oe,
  input  logic [PC_W-1:0]   pc_in,
  output logic [PC_W-1:0]   pc_out,
  output logic [PC_W-1:0]   pc_oe,
  input  logic [5:0]        px_io_in,
  output logic [5:0]        px_io_out,
  output logic [5:0]        px_io_oe,
  input  logic [22:0]       px_ipin,
  output logic [23:0]       px_opin
);

  localparam logic [ADDR_W-1:0] X_IN   = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] X_OSET = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] X_OCLR = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] X_OST  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] C_DSET = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] C_DCLR = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] C_DST  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] C_IN   = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] C_OSET = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] C_OCLR = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_OSET = ADDR_W'(8'h44);
  localparam logic [ADDR_W-1:0] A_OCLR = ADDR_W'(8'h48);
  localparam logic [ADDR_W-1:0] A_OST  = ADDR_W'(8'h4C);
  localparam logic [ADDR_W-1:0] A_DSET = ADDR_W'(8'h50);
  localparam logic [ADDR_W-1:0] A_DCLR = ADDR_W'(8'h54);
  localparam logic [ADDR_W-1:0] A_DST  = ADDR_W'(8'h58);
  localparam logic [ADDR_W-1:0] B_IN   = ADDR_W'(8'h60);
  localparam logic [ADDR_W-1:0] B_OSET = ADDR_W'(8'h64);
  localparam logic [ADDR_W-1:0] B_OCLR = ADDR_W'(8'h68);
  localparam logic [ADDR_W-1:0] B_OST  = ADDR_W'(8'h6C);
  localparam logic [ADDR_W-1:0] B_DSET = ADDR_W'(8'h70);
  localparam logic [ADDR_W-1:0] B_DCLR = ADDR_W'(8'h74);
  localparam logic [ADDR_W-1:0] B_DST  = ADDR_W'(8'h78);

  localparam int OFF_B  = PA_W;
  localparam int OFF_C  = OFF_B + PB_W;
  localparam int OFF_IO = OFF_C + PC_W;
  localparam int OFF_IP = OFF_IO + 6;
  localparam int IN_W   = OFF_IP + 23;

  logic [PA_W-1:0] a_out_q, a_dir_q;
  logic [PB_W-1:0] b_out_q, b_dir_q;
  logic [PC_W-1:0] c_out_q, c_dir_q;
  logic [5:0]      x_out_q, x_dir_q;
  logic [23:0]     x_opin_q;
  logic [IN_W-1:0] meta_q, sync_q;
  logic [31:0]     rd_word;
  logic [31:0]     x_in_word;
  logic [5:0]      wd_x;
  logic            unused_bits;

  assign wd_x        = bus_wdata[30:25];
  assign unused_bits = ^{bus_wdata[31], bus_wdata[24]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= {px_ipin, px_io_in, pc_in, pb_in, pa_in};
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_out_q  <= '0;
      a_dir_q  <= '0;
      b_out_q  <= '0;
      b_dir_q  <= '0;
      c_out_q  <= '0;
      c_dir_q  <= '0;
      x_out_q  <= '0;
      x_dir_q  <= '0;
      x_opin_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_OSET: a_out_q <= a_out_q | bus_wdata[PA_W-1:0];
        A_OCLR: a_out_q <= a_out_q & ~bus_wdata[PA_W-1:0];
        A_DSET: a_dir_q <= a_dir_q | bus_wdata[PA_W-1:0];
        A_DCLR: a_dir_q <= a_dir_q & ~bus_wdata[PA_W-1:0];
        B_OSET: b_out_q <= b_out_q | bus_wdata[PB_W-1:0];
        B_OCLR: b_out_q <= b_out_q & ~bus_wdata[PB_W-1:0];
        B_DSET: b_dir_q <= b_dir_q | bus_wdata[PB_W-1:0];
        B_DCLR: b_dir_q <= b_dir_q & ~bus_wdata[PB_W-1:0];
        C_OSET: c_out_q <= c_out_q | bus_wdata[PC_W-1:0];
        C_OCLR: c_out_q <= c_out_q & ~bus_wdata[PC_W-1:0];
        C_DSET: begin
          c_dir_q <= c_dir_q | bus_wdata[PC_W-1:0];
          x_dir_q <= x_dir_q | wd_x;
        end
        C_DCLR: begin
          c_dir_q <= c_dir_q & ~bus_wdata[PC_W-1:0];
          x_dir_q <= x_dir_q & ~wd_x;
        end
        X_OSET: begin
          x_opin_q <= x_opin_q | bus_wdata[23:0];
          x_out_q  <= x_out_q | wd_x;
        end
        X_OCLR: begin
          x_opin_q <= x_opin_q & ~bus_wdata[23:0];
          x_out_q  <= x_out_q & ~wd_x;
        end
        default: ;
      endcase
    end
  end

  assign x_in_word = {3'b000,
                      sync_q[OFF_IP+19 +: 4],
                      sync_q[OFF_IO+5],
                      sync_q[OFF_IP+10 +: 9],
                      sync_q[OFF_IO +: 5],
                      sync_q[OFF_IP +: 10]};

  always_comb begin
    rd_word = '0;
    case (bus_addr)
      X_IN:  rd_word = x_in_word;
      X_OST: rd_word = {1'b0, x_out_q, 1'b0, x_opin_q};
      C_DST: begin
        rd_word[30:25]     = x_dir_q;
        rd_word[PC_W-1:0]  = c_dir_q;
      end
      C_IN:  rd_word[PC_W-1:0] = sync_q[OFF_C +: PC_W];
      A_IN:  rd_word[PA_W-1:0] = sync_q[0 +: PA_W];
      A_OST: rd_word[PA_W-1:0] = a_out_q;
      A_DST: rd_word[PA_W-1:0] = a_dir_q;
      B_IN:  rd_word[PB_W-1:0] = sync_q[OFF_B +: PB_W];
      B_OST: rd_word[PB_W-1:0] = b_out_q;
      B_DST: rd_word[PB_W-1:0] = b_dir_q;
      default: ;
    endcase
  end

  assign bus_rdata = bus_rd ? rd_word : '0;

  assign pa_out    = a_out_q;
  assign pa_oe     = a_dir_q;
  assign pb_out    = b_out_q;
  assign pb_oe     = b_dir_q;
  assign pc_out    = c_out_q;
  assign pc_oe     = c_dir_q;
  assign px_io_out = x_out_q;
  assign px_io_oe  = x_dir_q;
  assign px_opin   = x_opin_q;

  logic [1:0] live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= '0;
    else if (live_q != 2'd3) live_q <= live_q + 2'd1;
  end

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == B_OSET && bus_wdata[0]) |=> pb_out[0]); // R3

  AST_CLEAR_MAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DCLR && bus_wdata[0]) |=> !pa_oe[0]); // R4

  AST_SHARED_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == C_DSET && bus_wdata[25]) |=> px_io_oe[0]); // R5

  AST_READONLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == A_OST || bus_addr == X_IN || bus_addr == C_DST))
    |=> ($stable(pa_out) && $stable(px_opin) && $stable(pc_oe) && $stable(px_io_oe))); // R9

  AST_TWO_STAGE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q == 2'd3 && bus_rd && bus_addr == A_IN)
    |-> bus_rdata[PA_W-1:0] == $past(pa_in, 2)); // R8

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 32'd0); // R10

endmodule

// File: tb/setclr_gpio_bench.sv
module setclr_gpio_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  pa_in = '0, pa_out, pa_oe;
  logic [23:0] pb_in = '0, pb_out, pb_oe;
  logic [12:0] pc_in = '0, pc_out, pc_oe;
  logic [5:0]  px_io_in = '0, px_io_out, px_io_oe;
  logic [22:0] px_ipin = '0;
  logic [23:0] px_opin;

  always #2.5 clk = ~clk;

  setclr_gpio u_setclr_gpio (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .px_io_in(px_io_in), .px_io_out(px_io_out), .px_io_oe(px_io_oe),
    .px_ipin(px_ipin), .px_opin(px_opin));

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0]  m_ao, m_ad;
  logic [23:0] m_bo, m_bd;
  logic [12:0] m_co, m_cd;
  logic [5:0]  m_xo, m_xd;
  logic [23:0] m_op;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] x_in_exp(input logic [5:0] io, input logic [22:0] ip);
    logic [31:0] w = '0;
    for (int i = 0; i < 10; i++) w[i] = ip[i];
    for (int i = 0; i < 9; i++)  w[15 + i] = ip[10 + i];
    for (int i = 0; i < 4; i++)  w[25 + i] = ip[19 + i];
    for (int i = 0; i < 5; i++)  w[10 + i] = io[i];
    w[24] = io[5];
    return w;
  endfunction

  function automatic logic [31:0] rd_exp(input logic [7:0] a);
    case (a)
      8'h00: return x_in_exp(px_io_in, px_ipin);
      8'h0C: return {1'b0, m_xo, 1'b0, m_op};
      8'h18: return {1'b0, m_xd, 12'd0, m_cd};
      8'h1C: return {19'd0, pc_in};
      8'h40: return {24'd0, pa_in};
      8'h4C: return {24'd0, m_ao};
      8'h58: return {24'd0, m_ad};
      8'h60: return {8'd0, pb_in};
      8'h6C: return {8'd0, m_bo};
      8'h78: return {8'd0, m_bd};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h44: m_ao = m_ao | d[7:0];
      8'h48: m_ao = m_ao & ~d[7:0];
      8'h50: m_ad = m_ad | d[7:0];
      8'h54: m_ad = m_ad & ~d[7:0];
      8'h64: m_bo = m_bo | d[23:0];
      8'h68: m_bo = m_bo & ~d[23:0];
      8'h70: m_bd = m_bd | d[23:0];
      8'h74: m_bd = m_bd & ~d[23:0];
      8'h20: m_co = m_co | d[12:0];
      8'h24: m_co = m_co & ~d[12:0];
      8'h10: begin m_cd = m_cd | d[12:0]; m_xd = m_xd | d[30:25]; end
      8'h14: begin m_cd = m_cd & ~d[12:0]; m_xd = m_xd & ~d[30:25]; end
      8'h04: begin m_op = m_op | d[23:0]; m_xo = m_xo | d[30:25]; end
      8'h08: begin m_op = m_op & ~d[23:0]; m_xo = m_xo & ~d[30:25]; end
      default: ;
    endcase
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic chk_pads(input string tag);
    chk({tag, " pa_out"}, {24'd0, pa_out}, {24'd0, m_ao});
    chk({tag, " pa_oe"},  {24'd0, pa_oe},  {24'd0, m_ad});
    chk({tag, " pb_out"}, {8'd0, pb_out},  {8'd0, m_bo});
    chk({tag, " pb_oe"},  {8'd0, pb_oe},   {8'd0, m_bd});
    chk({tag, " pc_out"}, {19'd0, pc_out}, {19'd0, m_co});
    chk({tag, " pc_oe"},  {19'd0, pc_oe},  {19'd0, m_cd});
    chk({tag, " px_io"},  {20'd0, px_io_oe, px_io_out}, {20'd0, m_xd, m_xo});
    chk({tag, " px_opin"}, {8'd0, px_opin}, {8'd0, m_op});
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, rd_exp(a));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    m_ao = '0; m_ad = '0; m_bo = '0; m_bd = '0; m_co = '0; m_cd = '0;
    m_xo = '0; m_xd = '0; m_op = '0;
    repeat (3) @(negedge clk);
    chk_pads("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_pads("R1 after reset");
    for (int a = 0; a < 128; a += 4) rd_chk("R1 readback zero", 8'(a));

    wr(8'h44, 32'h0000_00A5);
    wr(8'h48, 32'h0000_0005);
    chk("R3 set then clear pad", {24'd0, pa_out}, 32'h0000_00A0);
    rd_chk("R3 output state", 8'h4C);
    wr(8'h64, 32'h0080_0001);
    chk_pads("R3 port B edge bits");
    wr(8'h20, 32'h0000_1001);
    wr(8'h24, 32'h0000_0001);
    chk_pads("R3 port C");

    wr(8'h70, 32'h00F0_000F);
    wr(8'h74, 32'h0030_0003);
    chk("R4 dir mix", {8'd0, pb_oe}, 32'h00C0_000C);
    rd_chk("R4 dir state", 8'h78);
    wr(8'h50, 32'h0000_0081);
    rd_chk("R4 port A dir state", 8'h58);

    wr(8'h10, 32'hFFFF_FFFF);
    chk("R5 shared dir group pins", {26'd0, px_io_oe}, 32'h0000_003F);
    chk("R5 shared dir port C", {19'd0, pc_oe}, 32'h0000_1FFF);
    rd_chk("R5 dir state packing", 8'h18);
    wr(8'h14, 32'h0200_0001);
    chk_pads("R5 shared clear");

    wr(8'h04, 32'hFFFF_FFFF);
    chk("R6 output-only pins", {8'd0, px_opin}, 32'h00FF_FFFF);
    rd_chk("R6 output state packing", 8'h0C);
    wr(8'h08, 32'h4080_0001);
    chk_pads("R6 clear both kinds");

    @(negedge clk); px_io_in = 6'b100001; px_ipin = '0;
    repeat (3) @(negedge clk);
    rd(8'h00, v);
    chk("R7 bidir pins 0 and 5", v, 32'h0100_0400);
    @(negedge clk); px_io_in = '0; px_ipin = '1;
    repeat (3) @(negedge clk);
    rd(8'h00, v);
    chk("R7 input-only spread", v, 32'h1EFF_83FF);

    @(negedge clk); pa_in = 8'h00;
    repeat (3) @(negedge clk);
    @(negedge clk); pa_in = 8'h3C;
    rd(8'h40, v);
    chk("R8 one edge still old", v, 32'h0000_0000);
    rd(8'h40, v);
    chk("R8 two edges new", v, 32'h0000_003C);

    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h58, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    chk_pads("R9 read-only writes ignored");
    rd_chk("R9 output state unchanged", 8'h4C);
    rd_chk("R9 unmapped read", 8'h3C);
    rd_chk("R9 unmapped read 0x28", 8'h28);

    @(negedge clk);
    bus_addr = 8'h44; bus_wdata = 32'h0000_0002; bus_wr = 1'b1; bus_rd = 1'b1;
    #1 chk("R10 set address reads zero", bus_rdata, 32'd0);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    model_wr(8'h44, 32'h0000_0002);
    chk_pads("R10 write in read cycle");
    @(negedge clk);
    bus_addr = 8'h4C;
    #1 chk("R10 idle read zero", bus_rdata, 32'd0);

    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      @(negedge clk);
      pa_in = 8'($urandom()); pb_in = 24'($urandom()); pc_in = 13'($urandom());
      px_io_in = 6'($urandom()); px_ipin = 23'($urandom());
      a = 8'($urandom_range(0, 31) * 4);
      wr(a, $urandom());
      chk_pads("R3 R4 R5 R6 random pads");
      a = 8'($urandom_range(0, 31) * 4);
      rd_chk("R2 R7 R9 random readback", a);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule